// File: doc/BRIEF.md
# Descriptor-Ring Transmit DMA Channel

This block is one transmit DMA channel. Software lays out a ring of 16-byte descriptors in memory, each naming a buffer and a byte count, and tells the channel how far the valid part of the ring reaches by writing a stop offset. The channel fetches each descriptor in turn with single-beat 32-bit reads. It then reads the buffer a word at a time and streams its bytes in ascending address order on a byte-wide valid/ready output. Start-of-frame and last-byte markers come from the descriptor flags.

A small register port holds the control word, the stop offset and the ring base. It also returns two read-only status words: the state with the current offset, and the error code with the offset of the descriptor being worked on. The channel can suspend at frame boundaries and can check descriptor parity. It stops with a coded error on malformed descriptors or failed memory reads. It then stays halted until software disables it and enables it again.

Top module: `txdma_ring`

## Requirements
- R1: After reset, status word 0 (register 3) and status word 1 (register 4) read 0, and neither mem_req nor tx_valid is asserted.
- R2: A descriptor is four words at base + offset + 0, 4, 8 and 12. Word 0 carries start of frame in bit 31, end of frame in bit 30 and end of table in bit 28; bits 29 and 27:20 have no effect. Word 1 carries the byte count in bits 14:0 and the parity bit in bit 18, and its bits 17:16 have no effect. Word 2 is the buffer address. Word 3 affects only the parity check.
- R3: A descriptor with byte count N at address A produces N stream bytes, taken from A to A+N-1 in order, for any alignment of A. The byte at address a sits in lane a[1:0] of the 32-bit word, little-endian. tx_sof marks the first byte of a start-of-frame descriptor, and tx_last marks the final byte of an end-of-frame descriptor.
- R4: After a descriptor with end of table set, the current offset becomes 0. After any other descriptor it advances by 16, modulo 8192.
- R5: When the current offset equals the stop offset (register 1, bits 12:0), no descriptor is fetched and the state reads 2 (idle wait). Writing a different stop offset resumes fetching.
- R6: Status word 0 holds the current offset in bits 12:0 and the state in bits 31:28. The states are 0 disabled, 1 active, 2 idle wait, 3 stopped and 4 suspend pending.
- R7: The control register (register 0) uses bit 0 for enable, bit 1 for suspend request and bit 11 for parity-check disable. It reads back what was written in those bits. Register 2 holds the ring base.
- R8: With bit 11 clear, a descriptor whose four words XOR to a value with an odd number of ones gives error code 1 and state 3, and none of its bytes are sent. Status word 1 then shows error code 1 in bits 31:28 and the offset of that descriptor in bits 12:0. With bit 11 set, such a descriptor is sent normally.
- R9: A descriptor with byte count 0 and no end-of-frame flag gives error code 1 and state 3.
- R10: A read answered with mem_err gives error code 4 during a descriptor fetch and error code 3 during a buffer read, and the state goes to 3. Bytes already read are still sent.
- R11: After an error the channel issues no reads until enable is cleared and set again. Enabling again clears the error code and restarts at offset 0.
- R12: A suspend request takes effect only at a frame boundary. While a frame is in progress the state reads 4. Once the frame's last descriptor is done the state reads 3 and no fetch starts. Clearing the request resumes the channel.
- R13: After enable is cleared, the channel completes any outstanding read and waits for any offered byte to be accepted, then reads state 0 with offset 0, mem_req low and tx_valid low.
- R14: tx_valid, tx_data, tx_sof and tx_last hold steady until the byte is accepted. mem_req and mem_addr hold until mem_rvalid answers the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select: 0 control, 1 stop offset, 2 base, 3 status 0, 4 status 1 |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| mem_req | output | 1 | Read request pending |
| mem_addr | output | 32 | Word-aligned read address |
| mem_rvalid | input | 1 | Read answered this cycle |
| mem_err | input | 1 | Answered read failed (with mem_rvalid) |
| mem_rdata | input | 32 | Read data |
| tx_valid | output | 1 | Stream byte offered |
| tx_data | output | 8 | Stream byte |
| tx_sof | output | 1 | First byte of a frame |
| tx_last | output | 1 | Last byte of a frame |
| tx_ready | input | 1 | Stream sink accepts the byte |

## Verification
The bench uses random buffer alignments, lengths and reserved-bit values under random backpressure and random memory latency, and enough rounds to wrap the ring several times. A design that fetched buffers with the wrong lane order or skipped a word refetch at a lane boundary would scramble the stream. A design that ignored end of table would run off past the eighth slot. Directed cases aim at a suspend request raised mid-frame: an early stop would cut the frame and a late one would start the next. They also cover parity failures with and without the check disabled, zero-length non-final descriptors, and read errors on descriptor and buffer words, where a wrong halt would send bytes it must not. A disable while a byte is stalled checks that the byte is neither dropped nor duplicated.

// File: rtl/txdma_ring.sv
module txdma_ring #(
  parameter int AW   = 32,
  parameter int OFFW = 13,
  parameter int CNTW = 15
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic        mem_rvalid,
  input  logic        mem_err,
  input  logic [31:0] mem_rdata,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  output logic        tx_sof,
  output logic        tx_last,
  input  logic        tx_ready
);
  localparam logic [OFFW-1:0] DSTEP = OFFW'(16);
  localparam logic [3:0] S_DIS = 4'd0, S_ACT = 4'd1, S_IDLE = 4'd2, S_STOP = 4'd3, S_SPND = 4'd4;
  localparam logic [3:0] E_PROT = 4'd1, E_XFER = 4'd3, E_DRD = 4'd4;

  typedef enum logic [2:0] {P_DIS, P_DEC, P_DSC, P_DRD, P_SND, P_HLT} ph_t;

  ph_t             ph;
  logic            ctl_en, ctl_sus, ctl_pdis;
  logic [OFFW-1:0] ptr, cur, act;
  logic [AW-1:0]   base, baddr;
  logic [3:0]      err, st;
  logic [1:0]      widx;
  logic            f_sof, f_eof, f_eot, first, in_frame;
  logic [CNTW-1:0] cnt;
  logic [31:0]     pacc, word;

  wire             rsp = mem_req && mem_rvalid;
  wire             hs  = tx_valid && tx_ready;
  wire [OFFW-1:0]  nxt = f_eot ? '0 : cur + DSTEP;

  assign mem_req  = (ph == P_DSC) || (ph == P_DRD);
  assign mem_addr = (ph == P_DSC) ? base + AW'(cur) + AW'({widx, 2'b00})
                                  : {baddr[AW-1:2], 2'b00};
  assign tx_valid = (ph == P_SND);
  assign tx_data  = word[{baddr[1:0], 3'b000} +: 8];
  assign tx_sof   = f_sof && first;
  assign tx_last  = f_eof && (cnt == CNTW'(1));

  always_comb begin
    if (ph == P_DIS)                               st = S_DIS;
    else if (ph == P_HLT)                          st = S_STOP;
    else if (ctl_sus && !in_frame && ph == P_DEC)  st = S_STOP;
    else if (ctl_sus)                              st = S_SPND;
    else if (ph == P_DEC && cur == ptr)            st = S_IDLE;
    else                                           st = S_ACT;
  end

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = {20'h0, ctl_pdis, 9'h0, ctl_sus, ctl_en};
      3'd1:    reg_rdata = 32'(ptr);
      3'd2:    reg_rdata = 32'(base);
      3'd3:    reg_rdata = {st, 28'(cur)};
      3'd4:    reg_rdata = {err, 28'(act)};
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= P_DIS; ctl_en <= 1'b0; ctl_sus <= 1'b0; ctl_pdis <= 1'b0;
      ptr <= '0; cur <= '0; act <= '0; base <= '0; baddr <= '0;
      err <= '0; widx <= '0; f_sof <= 1'b0; f_eof <= 1'b0; f_eot <= 1'b0;
      first <= 1'b0; in_frame <= 1'b0; cnt <= '0; pacc <= '0; word <= '0;
    end else begin
      if (reg_wr) begin
        case (reg_addr)
          3'd0: begin ctl_en <= reg_wdata[0]; ctl_sus <= reg_wdata[1]; ctl_pdis <= reg_wdata[11]; end
          3'd1: ptr  <= reg_wdata[OFFW-1:0];
          3'd2: base <= reg_wdata[AW-1:0];
          default: ;
        endcase
      end
      case (ph)
        P_DIS: begin
          cur <= '0;
          if (ctl_en) begin ph <= P_DEC; err <= '0; act <= '0; in_frame <= 1'b0; end
        end
        P_DEC: begin
          if (!ctl_en) ph <= P_DIS;
          else if (!(ctl_sus && !in_frame) && cur != ptr) begin
            ph <= P_DSC; widx <= '0; act <= cur; pacc <= '0;
          end
        end
        P_DSC: if (rsp) begin
          if (mem_err) begin err <= E_DRD; ph <= P_HLT; end
          else if (!ctl_en) ph <= P_DIS;
          else begin
            pacc <= pacc ^ mem_rdata;
            widx <= widx + 2'd1;
            case (widx)
              2'd0: begin f_sof <= mem_rdata[31]; f_eof <= mem_rdata[30]; f_eot <= mem_rdata[28]; end
              2'd1: cnt   <= mem_rdata[CNTW-1:0];
              2'd2: baddr <= mem_rdata[AW-1:0];
              default: begin
                if ((!ctl_pdis && ^(pacc ^ mem_rdata)) || (cnt == '0 && !f_eof)) begin
                  err <= E_PROT; ph <= P_HLT;
                end else if (cnt == '0) begin
                  cur <= nxt; in_frame <= 1'b0; ph <= P_DEC;
                end else begin
                  first <= 1'b1; ph <= P_DRD;
                end
              end
            endcase
          end
        end
        P_DRD: if (rsp) begin
          if (mem_err) begin err <= E_XFER; ph <= P_HLT; end
          else if (!ctl_en) ph <= P_DIS;
          else begin word <= mem_rdata; ph <= P_SND; end
        end
        P_SND: if (hs) begin
          first <= 1'b0;
          baddr <= baddr + AW'(1);
          cnt   <= cnt - CNTW'(1);
          if (cnt == CNTW'(1)) begin
            cur <= nxt; in_frame <= !f_eof;
            ph  <= ctl_en ? P_DEC : P_DIS;
          end else if (!ctl_en) ph <= P_DIS;
          else if (baddr[1:0] == 2'd3) ph <= P_DRD;
        end
        P_HLT: if (!ctl_en) ph <= P_DIS;
        default: ph <= P_DIS;
      endcase
    end
  end

  a_r14_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_sof) && $stable(tx_last));
  a_r14_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_rvalid && !reg_wr |=> mem_req && $stable(mem_addr));
  a_r13_dis_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_DIS |-> !mem_req && !tx_valid);
  a_r11_err_stops: assert property (@(posedge clk) disable iff (!rst_n)
    err != 4'd0 && st != S_DIS |-> st == S_STOP && !mem_req);
  a_r4_cur_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    cur[3:0] == 4'd0);
endmodule

// File: tb/txdma_ring_bench.sv
module txdma_ring_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_rvalid, mem_err;
  logic [31:0] mem_addr, mem_rdata;
  logic        tx_valid, tx_sof, tx_last, tx_ready;
  logic [7:0]  tx_data;

  txdma_ring u_txdma_ring (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_err(mem_err),
    .mem_rdata(mem_rdata), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_sof(tx_sof), .tx_last(tx_last), .tx_ready(tx_ready));

  localparam int RING = 32'h1000;
  localparam int NDESC = 8;

  logic [31:0] mem [0:4095];
  logic [9:0]  expq[$];
  logic [9:0]  capq[$];
  int checks = 0, fails = 0;
  bit hold_rdy = 1'b0;
  int err_word = -1;
  int sw_idx = 0;
  logic [31:0] rv;

  initial begin
    mem_rvalid = 1'b0; mem_err = 1'b0; mem_rdata = '0; tx_ready = 1'b0;
    forever begin
      @(negedge clk);
      if (mem_req && !mem_rvalid && ($urandom % 3 != 0)) begin
        mem_rvalid = 1'b1;
        mem_rdata  = mem[mem_addr[13:2]];
        mem_err    = (int'(mem_addr[13:2]) == err_word);
      end else begin
        mem_rvalid = 1'b0; mem_err = 1'b0;
      end
      tx_ready = !hold_rdy && ($urandom % 4 != 0);
      if (tx_valid && tx_ready) capq.push_back({tx_sof, tx_last, tx_data});
    end
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic wait_st(input logic [3:0] s);
    for (int i = 0; i < 4000; i++) begin
      rd(3'd3, rv);
      if (rv[31:28] == s) return;
    end
  endtask

  task automatic wait_valid();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk); #1;
      if (tx_valid) return;
    end
  endtask

  task automatic set_byte(input int a, input logic [7:0] b);
    mem[a >> 2][8*(a % 4) +: 8] = b;
  endtask

  function automatic logic [12:0] doff(input int idx);
    return 13'(idx * 16);
  endfunction

  task automatic post(input bit sof, input bit eof, input int addr, input int cnt,
                      input bit badpar, input bit push);
    logic [31:0] w0, w1, w2, w3;
    logic [7:0] b;
    int wb;
    w0 = {sof, eof, 1'($urandom), (sw_idx == NDESC-1), 8'($urandom), 20'h0};
    w1 = {13'h0, 1'b0, 2'($urandom), 1'b0, 15'(cnt)};
    w2 = 32'(addr);
    w3 = $urandom;
    w1[18] = (^(w0 ^ w1 ^ w2 ^ w3)) ^ badpar;
    wb = (RING + sw_idx * 16) >> 2;
    mem[wb] = w0; mem[wb+1] = w1; mem[wb+2] = w2; mem[wb+3] = w3;
    for (int i = 0; i < cnt; i++) begin
      b = 8'($urandom);
      set_byte(addr + i, b);
      if (push) expq.push_back({sof && (i == 0), eof && (i == cnt - 1), b});
    end
    sw_idx = (sw_idx + 1) % NDESC;
  endtask

  task automatic cmp(input string tag);
    bit ok;
    int bad;
    ok = (capq.size() == expq.size());
    bad = -1;
    if (ok)
      for (int i = 0; i < expq.size(); i++)
        if (capq[i] !== expq[i] && bad < 0) begin bad = i; ok = 1'b0; end
    if (bad >= 0) check(ok, tag, 32'(capq[bad]), 32'(expq[bad]));
    else          check(ok, tag, capq.size(), expq.size());
    capq.delete(); expq.delete();
  endtask

  task automatic restart(input logic [31:0] ctl);
    wr(3'd0, 32'h0);
    wait_st(4'd0);
    wr(3'd1, 32'h0);
    sw_idx = 0;
    capq.delete(); expq.delete();
    wr(3'd0, ctl);
    wait_st(4'd2);
  endtask

  initial begin
    int nf, nd, ln, bump, start;
    void'($urandom(32'h0000_5eed));
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    repeat (5) @(posedge clk);
    rst_n = 1'b1;

    rd(3'd3, rv); check(rv == 32'h0, "R1 status0 after reset", rv, 0);
    rd(3'd4, rv); check(rv == 32'h0, "R1 status1 after reset", rv, 0);
    check(!mem_req && !tx_valid, "R1 outputs quiet", {mem_req, tx_valid}, 0);

    wr(3'd2, RING);
    wr(3'd0, 32'h1);
    rd(3'd0, rv); check(rv == 32'h1, "R7 control readback", rv, 1);
    wait_st(4'd2);
    check(rv == 32'h2000_0000, "R5 R6 idle at offset 0", rv, 32'h2000_0000);

    // random rounds: reserved bits and lanes vary, ring wraps
    for (int r = 0; r < 12; r++) begin
      bump = 0;
      nf = 1 + $urandom % 2;
      for (int f = 0; f < nf; f++) begin
        nd = 1 + $urandom % 3;
        for (int d = 0; d < nd; d++) begin
          ln = 1 + $urandom % 20;
          post(d == 0, d == nd - 1, 32'h2000 + bump, ln, 1'b0, 1'b1);
          bump += ln + $urandom % 3;
        end
      end
      wr(3'd1, 32'(doff(sw_idx)));
      repeat (3) @(negedge clk);
      wait_st(4'd2);
      check(rv[12:0] == doff(sw_idx), "R4 offset after round", rv[12:0], doff(sw_idx));
      cmp("R2 R3 stream round");
    end

    // R12: suspend raised mid-frame
    post(1, 0, 32'h2101, 16, 0, 1);
    post(0, 0, 32'h2203, 16, 0, 1);
    post(0, 1, 32'h2302, 16, 0, 1);
    start = sw_idx;
    post(1, 1, 32'h2400, 5, 0, 1);
    hold_rdy = 1'b1;
    wr(3'd1, 32'(doff(sw_idx)));
    wait_valid();
    wr(3'd0, 32'h3);
    rd(3'd3, rv); check(rv[31:28] == 4'd4, "R12 suspend pending", rv[31:28], 4);
    hold_rdy = 1'b0;
    wait_st(4'd3);
    repeat (20) @(negedge clk);
    rd(3'd3, rv);
    check(rv == {4'd3, 15'h0, doff(start)}, "R12 stopped at frame end", rv, {4'd3, 15'h0, doff(start)});
    check(capq.size() == 48, "R12 only first frame sent", capq.size(), 48);
    wr(3'd0, 32'h1);
    wait_st(4'd2);
    cmp("R12 stream after resume");

    // R8: parity failure halts
    post(1, 1, 32'h2500, 7, 0, 1);
    start = sw_idx;
    post(1, 1, 32'h2600, 9, 1, 0);
    wr(3'd1, 32'(doff(sw_idx)));
    wait_st(4'd3);
    rd(3'd4, rv);
    check(rv == {4'd1, 15'h0, doff(start)}, "R8 parity error code and offset", rv, {4'd1, 15'h0, doff(start)});
    repeat (10) @(negedge clk);
    check(!mem_req, "R11 no reads while halted", mem_req, 0);
    cmp("R8 no bytes from bad descriptor");
    wr(3'd0, 32'h0);
    wait_st(4'd0);
    repeat (3) @(negedge clk);
    rd(3'd3, rv); check(rv == 32'h0, "R13 disabled offset 0", rv, 0);
    restart(32'h1);
    rd(3'd4, rv); check(rv[31:28] == 4'd0, "R11 re-enable clears error", rv[31:28], 0);

    // R8: parity check disabled
    restart(32'h801);
    post(1, 1, 32'h2702, 11, 1, 1);
    wr(3'd1, 32'(doff(sw_idx)));
    repeat (3) @(negedge clk);
    wait_st(4'd2);
    cmp("R8 bad parity accepted when disabled");
    rd(3'd4, rv); check(rv[31:28] == 4'd0, "R8 no error when disabled", rv[31:28], 0);

    // R9: zero count without end of frame
    restart(32'h1);
    post(1, 0, 32'h2800, 0, 0, 0);
    wr(3'd1, 32'(doff(sw_idx)));
    wait_st(4'd3);
    rd(3'd4, rv); check(rv == {4'd1, 28'h0}, "R9 zero count protocol error", rv, {4'd1, 28'h0});

    // R10: descriptor read error
    restart(32'h1);
    err_word = (RING >> 2) + 1;
    post(1, 1, 32'h2900, 6, 0, 0);
    wr(3'd1, 32'(doff(sw_idx)));
    wait_st(4'd3);
    err_word = -1;
    rd(3'd4, rv); check(rv[31:28] == 4'd4, "R10 descriptor read error", rv[31:28], 4);
    cmp("R10 nothing sent on descriptor error");

    // R10: buffer read error after first word
    restart(32'h1);
    err_word = (32'h2a00 >> 2) + 1;
    post(1, 1, 32'h2a00, 12, 0, 1);
    while (expq.size() > 4) void'(expq.pop_back());
    wr(3'd1, 32'(doff(sw_idx)));
    wait_st(4'd3);
    err_word = -1;
    repeat (10) @(negedge clk);
    rd(3'd4, rv); check(rv == {4'd3, 28'h0}, "R10 data transfer error", rv, {4'd3, 28'h0});
    cmp("R10 bytes before error sent");

    // R13: disable while a byte is stalled
    restart(32'h1);
    post(1, 1, 32'h2b00, 8, 0, 1);
    while (expq.size() > 1) void'(expq.pop_back());
    hold_rdy = 1'b1;
    wr(3'd1, 32'(doff(sw_idx)));
    wait_valid();
    wr(3'd0, 32'h0);
    repeat (5) @(negedge clk);
    rd(3'd3, rv); check(rv[31:28] == 4'd1, "R13 waits for pending byte", rv[31:28], 1);
    hold_rdy = 1'b0;
    wait_st(4'd0);
    repeat (3) @(negedge clk);
    rd(3'd3, rv); check(rv == 32'h0, "R13 disabled after byte", rv, 0);
    check(!tx_valid && !mem_req, "R13 outputs quiet", {tx_valid, mem_req}, 0);
    cmp("R13 exactly one byte sent");

    finish_run();
  end
endmodule